// File: doc/BRIEF.md
# Adaptive-Speed Morse Character Decoder

This block turns a stream of envelope amplitudes (one non-negative value per audio sample) into decoded Morse characters. It sums the amplitudes over fixed frames of 64 samples and divides the sum by 64 to get a frame level. It keeps a slowly decaying peak of these levels. A frame whose level is above half that peak counts as key-down, and any other frame counts as key-up. Run lengths of key-down frames (marks) and key-up frames (spaces) are counted in frames.

A timing reference adapts to the sender's speed from the lengths of the marks. Each finished mark adds a 0 (dit) or a 1 (dash) to a symbol code. The code starts with a leading 1, so it is a binary-tree index. A long enough space ends the letter, and the code is then looked up to produce an ASCII character. A longer space produces a word space.

Samples enter on a valid/ready stream. Characters leave on a second valid/ready stream. Back-pressure works as follows. A character stays in the output register, stable, until `char_ready` takes it. While a character is waiting, and during the few cycles after each frame in which that frame is evaluated, `amp_ready` is low and no sample is taken. There is no output queue, so a slow consumer stalls the sample stream.

Top module: `morse_decoder`

## Requirements
- R1: After reset, `char_valid` is 0 and `amp_ready` is 1. The timing reference, the mark counter, the space counter and the peak are all 0, and the symbol code is 1. The first mark of 3 frames that follows reset, followed by one key-up frame, therefore yields 'T'.
- R2: Samples accepted on the input (`amp_valid` and `amp_ready` both high) are summed in groups of 64, and the frame level is the sum divided by 64, truncated. A character can appear only after the last sample of a frame. A frame whose sum is non-zero but whose level is 0 is still evaluated, as a key-up frame.
- R3: A frame whose sum is zero changes no state and emits nothing.
- R4: The peak first rises to the frame level if the level is higher. The frame is key-down if its level is greater than half of that peak. Key-down adds 1 to the mark count and clears the space count. At the end of every evaluated frame, the peak becomes peak*99/100 + level/100.
- R5: On a key-up frame, the space count adds 1. If both counts are then positive, a mark has ended, and two updates are tried in turn, each with integer division truncated toward zero. First, if mark > ref/100, ref becomes 4*ref/100 + 96*mark. Second, using the reference as it now stands, if ref/600 < mark < ref/300, ref becomes 96*ref/100 + 12*mark.
- R6: When a mark ends and mark > ref/600, one bit is shifted into the 8-bit symbol code from the right: 1 if mark > ref/200, otherwise 0. The mark count is cleared whenever a mark ends.
- R7: If space >= ref/200 and the code is above 1, the letter ends. A code below 128 emits its character, and a code of 128 or more emits nothing. In both cases the code returns to 1.
- R8: The character for each code is given in ASCII: 2 'E', 3 'T', 5 'A', 7 'M', 32 '5', and the other letters, digits and '+', '=', '/' at their dit=0/dash=1 tree positions. Any code with no entry, for example 19 (dit dit dash dash), gives '#' (0x23).
- R9: If space >= ref/67, a word space (0x20) is emitted, and it takes priority over a letter ending in the same frame. The space count is then set to -1000*(ref/100), so the next word space needs that many more key-up frames.
- R10: While `char_valid` is 1 and `char_ready` is 0, `char_valid` stays 1 and `char_code` stays stable. `amp_ready` is 0 whenever `char_valid` is 1.
- R11: Every emitted `char_code` lies in the range 0x20 to 0x5A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| amp_valid | input | 1 | An amplitude sample is offered |
| amp_ready | output | 1 | The block takes the offered sample at this edge |
| amp_data | input | AMP_W (12) | Non-negative envelope amplitude |
| char_valid | output | 1 | A decoded character is held |
| char_ready | input | 1 | The consumer takes the character at this edge |
| char_code | output | 8 | ASCII code of the decoded character |

## Verification
The main function is driven with keyed patterns built from constant-level frames: a first dash straight out of reset, trains of dashes that pull the timing reference up, and dit/dash mixes that spell known codes. The 'A' pattern only decodes correctly if the reference has adapted; without adaptation its first element would read as a dash and give 'M'. Other patterns separate the special cases: zero-sum frames from low but non-zero frames, a code of 128 from a code that is merely missing from the table, a level below half the peak from one above it, and a word space from the delay that follows it. A stalled consumer checks that the character is held stable and that the input stream is throttled.

// File: rtl/morse_pkg.sv
package morse_pkg;

  typedef enum logic [2:0] {
    ST_ACC,
    ST_KEY,
    ST_SLOW,
    ST_FAST,
    ST_BIT,
    ST_GAP,
    ST_DECAY
  } seq_state_t;

  localparam logic [7:0] CH_SPACE   = 8'h20;
  localparam logic [7:0] CH_UNKNOWN = 8'h23;
  localparam logic [7:0] CODE_EMPTY = 8'd1;

endpackage

// File: rtl/morse_frame_acc.sv
module morse_frame_acc #(
  parameter int AMP_W     = 12,
  parameter int FRAME_LEN = 64,
  localparam int CNT_W    = $clog2(FRAME_LEN),
  localparam int SUM_W    = AMP_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [AMP_W-1:0] amp,
  output logic             frame_done,
  output logic [SUM_W-1:0] frame_sum
);

  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] acc_next;

  assign acc_next = acc + SUM_W'(amp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      acc        <= '0;
      frame_done <= 1'b0;
      frame_sum  <= '0;
    end else begin
      frame_done <= 1'b0;
      if (take) begin
        if (cnt == CNT_W'(FRAME_LEN - 1)) begin
          cnt        <= '0;
          acc        <= '0;
          frame_sum  <= acc_next;
          frame_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          acc <= acc_next;
        end
      end
    end
  end

endmodule

// File: rtl/morse_lut.sv
module morse_lut (
  input  logic [7:0] code,
  output logic [7:0] ch
);
  import morse_pkg::*;

  always_comb begin
    case (code)
      8'd2:  ch = "E";
      8'd3:  ch = "T";
      8'd4:  ch = "I";
      8'd5:  ch = "A";
      8'd6:  ch = "N";
      8'd7:  ch = "M";
      8'd8:  ch = "S";
      8'd9:  ch = "U";
      8'd10: ch = "R";
      8'd11: ch = "W";
      8'd12: ch = "D";
      8'd13: ch = "K";
      8'd14: ch = "G";
      8'd15: ch = "O";
      8'd16: ch = "H";
      8'd17: ch = "V";
      8'd18: ch = "F";
      8'd20: ch = "L";
      8'd22: ch = "P";
      8'd23: ch = "J";
      8'd24: ch = "B";
      8'd25: ch = "X";
      8'd26: ch = "C";
      8'd27: ch = "Y";
      8'd28: ch = "Z";
      8'd29: ch = "Q";
      8'd32: ch = "5";
      8'd33: ch = "4";
      8'd35: ch = "3";
      8'd39: ch = "2";
      8'd42: ch = "+";
      8'd47: ch = "1";
      8'd48: ch = "6";
      8'd49: ch = "=";
      8'd50: ch = "/";
      8'd56: ch = "7";
      8'd60: ch = "8";
      8'd62: ch = "9";
      8'd63: ch = "0";
      default: ch = CH_UNKNOWN;
    endcase
  end

endmodule

// File: rtl/morse_seq.sv
module morse_seq #(
  parameter int SUM_W = 18,
  parameter int CNT_W = 6,
  parameter int TW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [SUM_W-1:0] frame_sum,
  input  logic [7:0]       lut_ch,
  input  logic             out_ready,
  output logic [7:0]       lut_code,
  output logic             busy,
  output logic             out_valid,
  output logic [7:0]       out_char
);
  import morse_pkg::*;

  localparam logic signed [TW-1:0] K0    = TW'(0);
  localparam logic signed [TW-1:0] K1    = TW'(1);
  localparam logic signed [TW-1:0] K2    = TW'(2);
  localparam logic signed [TW-1:0] K4    = TW'(4);
  localparam logic signed [TW-1:0] K12   = TW'(12);
  localparam logic signed [TW-1:0] K67   = TW'(67);
  localparam logic signed [TW-1:0] K96   = TW'(96);
  localparam logic signed [TW-1:0] K99   = TW'(99);
  localparam logic signed [TW-1:0] K100  = TW'(100);
  localparam logic signed [TW-1:0] K200  = TW'(200);
  localparam logic signed [TW-1:0] K300  = TW'(300);
  localparam logic signed [TW-1:0] K600  = TW'(600);
  localparam logic signed [TW-1:0] K1000 = TW'(1000);

  seq_state_t state;

  logic signed [TW-1:0] tref;
  logic signed [TW-1:0] peak;
  logic signed [TW-1:0] mark;
  logic signed [TW-1:0] space;
  logic signed [TW-1:0] level;
  logic [7:0]           code;

  // per-step decisions, each on the registered state of the previous step
  logic signed [TW-1:0] pk_up, space_inc, slow_ref, fast_ref, decay_pk, hold_space;
  logic                 key_dn, slow_hit, fast_hit, bit_keep, bit_dash;
  logic                 letter_hit, word_hit;

  always_comb begin
    pk_up      = (level > peak) ? level : peak;
    key_dn     = level > (pk_up / K2);
    space_inc  = space + K1;
    slow_hit   = mark > (tref / K100);
    slow_ref   = (K4 * tref) / K100 + K96 * mark;
    fast_hit   = (mark > (tref / K600)) && (mark < (tref / K300));
    fast_ref   = (K96 * tref) / K100 + K12 * mark;
    bit_keep   = mark > (tref / K600);
    bit_dash   = mark > (tref / K200);
    letter_hit = (space >= (tref / K200)) && (code > CODE_EMPTY);
    word_hit   = space >= (tref / K67);
    hold_space = -(K1000 * (tref / K100));
    decay_pk   = (K99 * peak) / K100 + level / K100;
  end

  assign lut_code = code;
  assign busy     = (state != ST_ACC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_ACC;
      tref      <= K0;
      peak      <= K0;
      mark      <= K0;
      space     <= K0;
      level     <= K0;
      code      <= CODE_EMPTY;
      out_valid <= 1'b0;
      out_char  <= CH_SPACE;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_ACC: begin
          if (frame_done && (frame_sum != '0)) begin
            level <= TW'(frame_sum >> CNT_W);
            state <= ST_KEY;
          end
        end
        ST_KEY: begin
          peak <= pk_up;
          if (key_dn) begin
            mark  <= mark + K1;
            space <= K0;
            state <= ST_DECAY;
          end else begin
            space <= space_inc;
            state <= ((space_inc > K0) && (mark > K0)) ? ST_SLOW : ST_GAP;
          end
        end
        ST_SLOW: begin
          if (slow_hit) tref <= slow_ref;
          state <= ST_FAST;
        end
        ST_FAST: begin
          if (fast_hit) tref <= fast_ref;
          state <= ST_BIT;
        end
        ST_BIT: begin
          if (bit_keep) code <= {code[6:0], bit_dash};
          mark  <= K0;
          state <= ST_GAP;
        end
        ST_GAP: begin
          if (letter_hit) code <= CODE_EMPTY;
          if (word_hit) begin
            space     <= hold_space;
            out_char  <= CH_SPACE;
            out_valid <= 1'b1;
          end else if (letter_hit && !code[7]) begin
            out_char  <= lut_ch;
            out_valid <= 1'b1;
          end
          state <= ST_DECAY;
        end
        ST_DECAY: begin
          peak  <= decay_pk;
          state <= ST_ACC;
        end
        default: state <= ST_ACC;
      endcase
    end
  end

endmodule

// File: rtl/morse_decoder.sv
module morse_decoder #(
  parameter int AMP_W     = 12,
  parameter int FRAME_LEN = 64,
  parameter int TW        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             amp_valid,
  output logic             amp_ready,
  input  logic [AMP_W-1:0] amp_data,
  output logic             char_valid,
  input  logic             char_ready,
  output logic [7:0]       char_code
);

  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam int SUM_W = AMP_W + CNT_W;

  logic             take;
  logic             frame_done;
  logic [SUM_W-1:0] frame_sum;
  logic [7:0]       lut_code;
  logic [7:0]       lut_ch;
  logic             busy;

  assign amp_ready = !busy && !char_valid && !frame_done;
  assign take      = amp_valid && amp_ready;

  morse_frame_acc #(.AMP_W(AMP_W), .FRAME_LEN(FRAME_LEN)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .amp        (amp_data),
    .frame_done (frame_done),
    .frame_sum  (frame_sum)
  );

  morse_lut u_lut (
    .code (lut_code),
    .ch   (lut_ch)
  );

  morse_seq #(.SUM_W(SUM_W), .CNT_W(CNT_W), .TW(TW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_sum  (frame_sum),
    .lut_ch     (lut_ch),
    .out_ready  (char_ready),
    .lut_code   (lut_code),
    .busy       (busy),
    .out_valid  (char_valid),
    .out_char   (char_code)
  );

endmodule

// File: rtl/morse_decoder_chk.sv
module morse_decoder_chk #(
  parameter int FRAME_LEN = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       amp_valid,
  input logic       amp_ready,
  input logic       char_valid,
  input logic       char_ready,
  input logic [7:0] char_code
);
  localparam int CW = $clog2(FRAME_LEN);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (amp_valid && amp_ready) seen <= seen + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!char_valid && amp_ready));

  assert_frame_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_valid) |-> (seen == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ready) |=> (char_valid && $stable(char_code)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> !amp_ready);

  assert_charset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> ((char_code >= 8'h20) && (char_code <= 8'h5A)));

endmodule

bind morse_decoder morse_decoder_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .amp_valid  (amp_valid),
  .amp_ready  (amp_ready),
  .char_valid (char_valid),
  .char_ready (char_ready),
  .char_code  (char_code)
);

// File: tb/morse_decoder_tb.sv
module morse_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        amp_valid = 1'b0;
  logic        amp_ready;
  logic [11:0] amp_data = '0;
  logic        char_valid;
  logic        char_ready = 1'b1;
  logic [7:0]  char_code;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] rx [0:63];
  int rx_n = 0;

  always #4 clk = ~clk;

  morse_decoder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .amp_valid  (amp_valid),
    .amp_ready  (amp_ready),
    .amp_data   (amp_data),
    .char_valid (char_valid),
    .char_ready (char_ready),
    .char_code  (char_code)
  );

  always @(negedge clk) begin
    if (rst_n && char_valid && char_ready) begin
      if (rx_n < 64) rx[rx_n] = char_code;
      rx_n = rx_n + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int a);
    forever begin
      @(negedge clk);
      amp_valid = 1'b1;
      amp_data  = 12'(a);
      if (amp_ready) begin
        @(posedge clk);
        break;
      end
    end
  endtask

  task automatic frames(input int a, input int n);
    for (int f = 0; f < n; f++)
      for (int s = 0; s < 64; s++) push(a);
    @(negedge clk);
    amp_valid = 1'b0;
  endtask

  // one sample of 63 then zeros: non-zero sum, level 0
  task automatic low_frames(input int n);
    for (int f = 0; f < n; f++)
      for (int s = 0; s < 64; s++) push(s == 0 ? 63 : 0);
    @(negedge clk);
    amp_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  // d frames per dit, 3d per dash, d between elements, gap after last
  task automatic letter(input string pat, input int lvl, input int d, input int gap);
    for (int i = 0; i < pat.len(); i++) begin
      frames(lvl, (pat[i] == "-") ? 3 * d : d);
      frames(1, (i == pat.len() - 1) ? gap : d);
    end
    settle();
  endtask

  task automatic t_reset();
    chk("R1 char_valid after reset", int'(char_valid), 0);
    chk("R1 amp_ready after reset", int'(amp_ready), 1);
  endtask

  task automatic t_first_mark();
    frames(400, 3);
    frames(1, 1);
    settle();
    chk("R1 R6 first mark count", rx_n, 1);
    chk("R8 first mark char T", int'(rx[0]), int'("T"));
  endtask

  task automatic t_zero_and_word();
    frames(0, 10);
    settle();
    chk("R3 zero-sum frames emit nothing", rx_n, 1);
    low_frames(2);
    settle();
    chk("R2 R9 no word space before threshold", rx_n, 1);
    low_frames(1);
    settle();
    chk("R2 R9 word space count", rx_n, 2);
    chk("R9 word space code", int'(rx[1]), 32);
    frames(1, 20);
    settle();
    chk("R9 word space delayed", rx_n, 2);
  endtask

  task automatic t_train();
    for (int k = 0; k < 3; k++) letter("-", 400, 3, 9);
    chk("R5 training count", rx_n, 5);
    chk("R5 training chars", int'({rx[2], rx[3], rx[4]}), int'({8'h54, 8'h54, 8'h54}));
  endtask

  task automatic t_adapted();
    letter(".-", 400, 3, 9);
    chk("R5 R6 R8 adapted dit gives A", int'(rx[5]), int'("A"));
    letter(".", 400, 3, 21);
    chk("R7 R9 E then word count", rx_n, 8);
    chk("R7 R9 E then word chars", int'({rx[6], rx[7]}), int'({8'h45, 8'h20}));
  endtask

  task automatic t_peak();
    frames(100, 9);
    frames(1, 9);
    settle();
    chk("R4 level below half peak is key-up", rx_n, 8);
    letter("-", 250, 3, 9);
    chk("R4 level above half peak is key-down", int'(rx[8]), int'("T"));
  endtask

  task automatic t_codes();
    letter(".......", 400, 3, 9);
    chk("R7 code 128 emits nothing", rx_n, 9);
    letter(".", 400, 3, 9);
    chk("R7 code restarts at 1", int'(rx[9]), int'("E"));
    letter("..--", 400, 3, 9);
    chk("R8 code 19 unknown", int'(rx[10]), int'("#"));
    letter(".....", 400, 3, 9);
    chk("R8 code 32 digit 5", int'(rx[11]), int'("5"));
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    char_ready = 1'b0;
    frames(400, 3);
    frames(1, 4);
    settle();
    chk("R10 held valid", int'(char_valid), 1);
    chk("R10 held code", int'(char_code), int'("E"));
    chk("R10 input stalled", int'(amp_ready), 0);
    repeat (10) @(negedge clk);
    chk("R10 code stable", int'(char_code), int'("E"));
    char_ready = 1'b1;
    settle();
    frames(1, 5);
    settle();
    chk("R10 delivered once", rx_n, 13);
    chk("R10 input resumes", int'(amp_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_mark();
    t_zero_and_word();
    t_train();
    t_adapted();
    t_peak();
    t_codes();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule